// File: doc/BRIEF.md
# Conversion Result Readout

This block stores the results of a six-channel, two-converter sampling front end and hands them to a host over a 16-bit parallel bus. A conversion sequencer delivers each finished result as a one-cycle write request made of a 3-bit channel code and a 12-bit value. Every result is kept twice: once in a per-channel register that always shows the latest value of that channel, and once in a six-deep first-in first-out queue that records results in arrival order.

The host reads with an active-low chip select and an active-low read strobe. A 3-bit selector picks the read discipline. It can address one channel directly, step through all six channels in a fixed rotation, or drain the queue. Each word describes itself: it carries a valid flag, the channel tag and the data. With byte mode set, a word is delivered as two 8-bit reads on the low half of the bus. The strobes are sampled through a synchroniser into the block clock. A read is complete when the combined strobe rises. Results that arrive while a read is in progress are parked and written only after the strobe is released.

Top module: `readout_unit`

## Requirements
- R1: An output word holds the valid flag in bit 15, the channel code in bits 14:12 and the 12-bit result in bits 11:0, with the most significant result bit in bit 11.
- R2: Channel codes are 0 to 5 for A0, A1, B0, B1, C0 and C1. A selector value from 0 to 5 returns the most recent result of that channel, with its code in bits 14:12 and a valid flag of 1, or a valid flag of 0 and zero data if no result has arrived since reset.
- R3: With selector 6, successive completed reads return channels 0, 1, 2, 3, 4, 5 and then 0 again. The first read after reset returns channel 0.
- R4: With selector 7, reads return queued results in arrival order, each with valid flag 1 and its own channel code. Completing a read removes the head entry, and the remaining entries move down one place.
- R5: With selector 7 and an empty queue, the whole word reads 0, so the valid flag is 0, and no entry is removed.
- R6: A result that arrives while the synchronised combined read is active is not written until that read completes. The word on the bus stays unchanged for the rest of that read, and the result is readable afterwards.
- R7: The bus is driven, and the drive-enable output is 1, only while chip select and read strobe are both low. Otherwise the bus is high-impedance and the drive enable is 0.
- R8: With byte mode set, bits 15:8 of the bus read 0. The first read of a word puts word bits 7:0 on bus bits 7:0, and the second read puts word bits 15:8 there. The rotation or queue advances only after the second read.
- R9: Reset clears all channel registers, empties the queue, returns the rotation to channel 0, clears the byte phase and clears the overflow flag.
- R10: A result that arrives with six entries already queued is left out of the queue and sets a sticky overflow flag that stays set until reset. The per-channel register is still updated.
- R11: Reads with a selector value from 0 to 5 neither advance the rotation nor remove queue entries.
- R12: Write requests with channel code 6 or 7 change neither the channel registers nor the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_we | input | 1 | One-cycle result write request from the sequencer |
| res_code | input | 3 | Channel code of the result |
| res_data | input | 12 | Result value |
| cs_n | input | 1 | Host chip select, active low |
| rd_n | input | 1 | Host read strobe, active low |
| sel | input | 3 | Channel address (0 to 5), rotation (6) or queue (7) |
| byte_mode | input | 1 | Deliver each word as two 8-bit reads |
| db | output | 16 | Tristate read data bus |
| bus_oe | output | 1 | High while the block drives the bus |
| ovf_flag | output | 1 | Sticky queue overflow flag |

## Verification
The bench goes after the edges of the queue. A seventh write into a full queue must be dropped and not overwrite the tail. A read of an empty queue must report valid 0 and must not wrap the fill count. A design that got these wrong would return a stale or duplicated entry during the drain, or leave the overflow flag clear. It also targets the write that lands while a read is held low: a design without hold-off would change the word under a live read, or would lose the result. The rotation is checked across a wrap and after direct reads, where an early advance skips a channel. Byte mode is checked against the half order and against an advance on the first half, which would drop the high byte of every word.

// File: rtl/readout_pkg.sv
package readout_pkg;
  localparam int unsigned DATA_W = 12;
  localparam int unsigned CODE_W = 3;
  localparam int unsigned WORD_W = 1 + CODE_W + DATA_W;
  localparam int unsigned HALF_W = WORD_W / 2;

  localparam logic [CODE_W-1:0] SEL_CYCLE = 3'b110;
  localparam logic [CODE_W-1:0] SEL_FIFO  = 3'b111;

  typedef struct packed {
    logic [CODE_W-1:0] code;
    logic [DATA_W-1:0] data;
  } result_t;
endpackage

// File: rtl/readout_sync.sv
module readout_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2,
  parameter bit          RST_VAL = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES*W-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {(STAGES*W){RST_VAL}};
        else        chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {(STAGES*W){RST_VAL}};
        else        chain <= {chain[(STAGES-1)*W-1:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES*W-1 -: W];
endmodule

// File: rtl/readout_chan_bank.sv
module readout_chan_bank
  import readout_pkg::*;
#(
  parameter int unsigned NCH = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [CODE_W-1:0] wcode,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CODE_W-1:0] rcode,
  output logic              rvalid,
  output logic [DATA_W-1:0] rdata
);
  localparam logic [CODE_W-1:0] NCH_C = CODE_W'(NCH);

  logic [NCH-1:0]    vld;
  logic [DATA_W-1:0] dat [NCH];
  logic              hit;

  assign hit = we && (wcode < NCH_C);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= '0;
      for (int c = 0; c < NCH; c++) dat[c] <= '0;
    end else if (hit) begin
      vld[wcode] <= 1'b1;
      dat[wcode] <= wdata;
    end
  end

  always_comb begin
    rvalid = 1'b0;
    rdata  = '0;
    if (rcode < NCH_C) begin
      rvalid = vld[rcode];
      rdata  = dat[rcode];
    end
  end
endmodule

// File: rtl/readout_fifo.sv
module readout_fifo
  import readout_pkg::*;
#(
  parameter int unsigned DEPTH = 6,
  parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  result_t          din,
  input  logic             pop,
  output result_t          head,
  output logic [CNT_W-1:0] fill,
  output logic             drop
);
  localparam int unsigned PTR_W = $clog2(DEPTH);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  result_t          mem    [DEPTH];
  result_t          mem_nx [DEPTH];
  logic [CNT_W-1:0] cnt, cnt_nx;

  always_comb begin
    mem_nx = mem;
    cnt_nx = cnt;
    drop   = 1'b0;
    if (pop && (cnt != '0)) begin
      for (int i = 0; i < DEPTH - 1; i++) mem_nx[i] = mem[i+1];
      mem_nx[DEPTH-1] = '0;
      cnt_nx = cnt - ONE;
    end
    if (push) begin
      if (cnt_nx < FULL) begin
        mem_nx[cnt_nx[PTR_W-1:0]] = din;
        cnt_nx = cnt_nx + ONE;
      end else begin
        drop = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      cnt <= cnt_nx;
      mem <= mem_nx;
    end
  end

  assign head = (cnt != '0) ? mem[0] : '0;
  assign fill = cnt;
endmodule

// File: rtl/readout_unit.sv
module readout_unit
  import readout_pkg::*;
#(
  parameter int unsigned NCH         = 6,
  parameter int unsigned DEPTH       = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              res_we,
  input  logic [CODE_W-1:0] res_code,
  input  logic [DATA_W-1:0] res_data,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic [CODE_W-1:0] sel,
  input  logic              byte_mode,
  output wire  [WORD_W-1:0] db,
  output logic              bus_oe,
  output logic              ovf_flag
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam int unsigned IDX_W = $clog2(NCH);
  localparam logic [IDX_W-1:0]  PTR_LAST = IDX_W'(NCH - 1);
  localparam logic [CODE_W-1:0] NCH_C    = CODE_W'(NCH);

  // reset: asserted at once, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_i = rst_pipe[1];

  // host strobes into the clock domain
  logic [1:0] strb_s;
  logic       rd_act, rd_act_q, rd_done, word_done;
  readout_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_i), .d({cs_n, rd_n}), .q(strb_s)
  );
  assign rd_act = ~strb_s[1] & ~strb_s[0];

  // state
  logic             hi_q, hi_nx;
  logic [IDX_W-1:0] cyc_ptr, ptr_nx;
  logic             pend_v, pend_v_nx;
  result_t          pend_r, pend_nx;
  logic             ovf_nx;
  logic             commit;
  result_t          cmt, incoming;
  logic             fifo_drop;
  logic [CNT_W-1:0] fifo_fill;
  result_t          fifo_head;
  logic             bank_v;
  logic [DATA_W-1:0] bank_d;
  logic [CODE_W-1:0] rsel_code;
  logic             pop;

  assign rd_done   = rd_act_q & ~rd_act;
  assign word_done = rd_done & (~byte_mode | hi_q);
  assign pop       = word_done && (sel == SEL_FIFO);
  assign incoming  = '{code: res_code, data: res_data};

  always_comb begin
    hi_nx     = byte_mode ? (rd_done ? ~hi_q : hi_q) : 1'b0;
    ptr_nx    = cyc_ptr;
    if (word_done && (sel == SEL_CYCLE))
      ptr_nx = (cyc_ptr == PTR_LAST) ? '0 : cyc_ptr + IDX_W'(1);
    commit    = 1'b0;
    cmt       = incoming;
    pend_v_nx = pend_v;
    pend_nx   = pend_r;
    if (!rd_act) begin
      if (pend_v) begin
        commit    = 1'b1;
        cmt       = pend_r;
        pend_v_nx = res_we;
        pend_nx   = res_we ? incoming : pend_r;
      end else begin
        commit = res_we;
      end
    end else if (res_we) begin
      pend_v_nx = 1'b1;
      pend_nx   = incoming;
    end
    ovf_nx = ovf_flag | fifo_drop;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      rd_act_q <= 1'b0;
      hi_q     <= 1'b0;
      cyc_ptr  <= '0;
      pend_v   <= 1'b0;
      pend_r   <= '0;
      ovf_flag <= 1'b0;
    end else begin
      rd_act_q <= rd_act;
      hi_q     <= hi_nx;
      cyc_ptr  <= ptr_nx;
      pend_v   <= pend_v_nx;
      pend_r   <= pend_nx;
      ovf_flag <= ovf_nx;
    end
  end

  readout_chan_bank #(.NCH(NCH)) u_bank (
    .clk(clk), .rst_n(rst_i), .we(commit), .wcode(cmt.code), .wdata(cmt.data),
    .rcode(rsel_code), .rvalid(bank_v), .rdata(bank_d)
  );

  readout_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_i), .push(commit && (cmt.code < NCH_C)), .din(cmt),
    .pop(pop), .head(fifo_head), .fill(fifo_fill), .drop(fifo_drop)
  );

  // read word
  logic [WORD_W-1:0] word, bus_word;
  always_comb begin
    rsel_code = (sel == SEL_CYCLE) ? CODE_W'(cyc_ptr) : sel;
    if (sel == SEL_FIFO)
      word = (fifo_fill != '0) ? {1'b1, fifo_head} : '0;
    else
      word = {bank_v, rsel_code, bank_d};
    if (byte_mode)
      bus_word = {{HALF_W{1'b0}}, (hi_q ? word[WORD_W-1:HALF_W] : word[HALF_W-1:0])};
    else
      bus_word = word;
  end

  assign bus_oe = ~cs_n & ~rd_n;
  assign db     = bus_oe ? bus_word : {WORD_W{1'bz}};
endmodule

// File: rtl/readout_unit_chk.sv
module readout_unit_chk
  import readout_pkg::*;
#(
  parameter int unsigned NCH   = 6,
  parameter int unsigned DEPTH = 6,
  parameter int unsigned CNT_W = $clog2(DEPTH + 1),
  parameter int unsigned IDX_W = $clog2(NCH)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              rd_n,
  input logic [CODE_W-1:0] sel,
  input logic              byte_mode,
  input logic [WORD_W-1:0] db,
  input logic              bus_oe,
  input logic              ovf_flag,
  input logic [CNT_W-1:0]  fill,
  input logic [IDX_W-1:0]  cyc_ptr,
  input logic              rd_act
);
  AST_BUS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || rd_n) |-> !bus_oe); // R7

  AST_EMPTY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && sel == SEL_FIFO && !byte_mode && fill == '0) |-> !db[WORD_W-1]); // R5

  AST_FILL_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CNT_W'(DEPTH)); // R10

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag |=> ovf_flag); // R10

  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    rd_act |=> $stable(fill)); // R6

  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_act |=> $stable(cyc_ptr)); // R11

  AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_ptr < IDX_W'(NCH)); // R3
endmodule

bind readout_unit readout_unit_chk #(.NCH(NCH), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .sel(sel),
  .byte_mode(byte_mode), .db(db), .bus_oe(bus_oe), .ovf_flag(ovf_flag),
  .fill(fifo_fill), .cyc_ptr(cyc_ptr), .rd_act(rd_act)
);

// File: tb/readout_unit_bench.sv
module readout_unit_bench;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        res_we = 1'b0;
  logic [2:0]  res_code = '0;
  logic [11:0] res_data = '0;
  logic        cs_n = 1'b1;
  logic        rd_n = 1'b1;
  logic [2:0]  sel = '0;
  logic        byte_mode = 1'b0;
  wire  [15:0] db;
  logic        bus_oe;
  logic        ovf_flag;

  always #(CLK_NS/2) clk = ~clk;

  readout_unit u_readout_unit (
    .clk(clk), .rst_n(rst_n), .res_we(res_we), .res_code(res_code),
    .res_data(res_data), .cs_n(cs_n), .rd_n(rd_n), .sel(sel),
    .byte_mode(byte_mode), .db(db), .bus_oe(bus_oe), .ovf_flag(ovf_flag)
  );

  int nchk = 0;
  int nerr = 0;

  // expectation model built from the requirements
  logic        mv [6];
  logic [11:0] md [6];
  logic [2:0]  qc [6];
  logic [11:0] qd [6];
  int          qn;
  int          ptr;
  bit          ph;
  bit          movf;

  function automatic logic [11:0] pat(input int c, input int k);
    return 12'((c * 397 + k * 211 + 5) % 4096);
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int c = 0; c < 6; c++) begin mv[c] = 1'b0; md[c] = '0; end
    qn = 0; ptr = 0; ph = 1'b0; movf = 1'b0;
  endtask

  task automatic model_write(input logic [2:0] c, input logic [11:0] d);
    if (c < 3'd6) begin
      mv[c] = 1'b1; md[c] = d;
      if (qn < 6) begin qc[qn] = c; qd[qn] = d; qn++; end
      else movf = 1'b1;
    end
  endtask

  task automatic do_write(input logic [2:0] c, input logic [11:0] d);
    @(negedge clk);
    res_we = 1'b1; res_code = c; res_data = d;
    @(negedge clk);
    res_we = 1'b0;
    model_write(c, d);
  endtask

  function automatic logic [15:0] exp_word(input logic [2:0] m, input bit b);
    logic [15:0] w;
    logic [2:0]  c;
    if (m == 3'd7) w = (qn > 0) ? {1'b1, qc[0], qd[0]} : 16'h0000;
    else begin
      c = (m == 3'd6) ? 3'(ptr) : m;
      w = {mv[c], c, md[c]};
    end
    if (b) w = {8'h00, (ph ? w[15:8] : w[7:0])};
    return w;
  endfunction

  task automatic do_read(input logic [2:0] m, input bit b, input string tag);
    bit adv;
    @(negedge clk);
    sel = m; byte_mode = b; cs_n = 1'b0; rd_n = 1'b0;
    if (!b) ph = 1'b0;
    repeat (4) @(negedge clk);
    chk(tag, db, exp_word(m, b));
    chk("R7 drive enable during read", {15'd0, bus_oe}, 16'd1);
    rd_n = 1'b1; cs_n = 1'b1;
    repeat (5) @(negedge clk);
    adv = !b || ph;
    ph  = b ? !ph : 1'b0;
    if (adv) begin
      if (m == 3'd6) ptr = (ptr + 1) % 6;
      if (m == 3'd7 && qn > 0) begin
        for (int i = 0; i < 5; i++) begin qc[i] = qc[i+1]; qd[i] = qd[i+1]; end
        qn--;
      end
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cs_n = 1'b1; rd_n = 1'b1; res_we = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    model_clear();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    nchk++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [15:0] old;
    model_clear();
    do_reset();
    chk("R7 idle drive enable", {15'd0, bus_oe}, 16'd0);
    chk("R9 overflow after reset", {15'd0, ovf_flag}, 16'd0);
    for (int c = 0; c < 6; c++) do_read(3'(c), 1'b0, "R9 R2 cleared channel");
    do_read(3'd7, 1'b0, "R5 empty queue");

    // R12: unused codes leave everything untouched
    do_write(3'd6, 12'hABC);
    do_write(3'd7, 12'h123);
    do_read(3'd7, 1'b0, "R12 queue unchanged");
    do_read(3'd0, 1'b0, "R12 channel unchanged");

    // sweep: fill and drain the queue with several patterns
    for (int k = 1; k <= 3; k++) begin
      for (int c = 0; c < 6; c++) do_write(3'((c + k) % 6), pat(c, k));
      for (int c = 0; c < 6; c++) do_read(3'(c), 1'b0, "R1 R2 direct sweep");
      for (int i = 0; i < 6; i++) do_read(3'd7, 1'b0, "R4 queue order sweep");
    end

    for (int c = 0; c < 6; c++) do_write(3'(c), pat(c, 0));
    for (int c = 0; c < 6; c++) do_read(3'(c), 1'b0, "R2 R11 direct read");
    for (int i = 0; i < 13; i++) do_read(3'd6, 1'b0, "R3 R11 rotation");

    // R10: queue full
    do_write(3'd2, pat(2, 9));
    chk("R10 overflow set", {15'd0, ovf_flag}, 16'd1);
    do_read(3'd2, 1'b0, "R10 channel register updated");
    for (int i = 0; i < 7; i++) do_read(3'd7, 1'b0, "R4 R5 queue drain");
    chk("R10 overflow sticky", {15'd0, ovf_flag}, 16'd1);

    // R8: byte mode on every discipline
    do_write(3'd3, pat(3, 7));
    do_read(3'd3, 1'b1, "R8 direct low half");
    do_read(3'd3, 1'b1, "R8 direct high half");
    for (int i = 0; i < 4; i++) do_read(3'd6, 1'b1, "R8 rotation halves");
    for (int i = 0; i < 3; i++) do_read(3'd7, 1'b1, "R8 queue halves");
    do_read(3'd6, 1'b0, "R8 rotation after byte reads");

    // R6: result arriving during a held read
    @(negedge clk);
    sel = 3'd4; byte_mode = 1'b0; cs_n = 1'b0; rd_n = 1'b0;
    repeat (4) @(negedge clk);
    old = {mv[4], 3'd4, md[4]};
    chk("R6 word before write", db, old);
    res_we = 1'b1; res_code = 3'd4; res_data = pat(4, 5);
    @(negedge clk);
    res_we = 1'b0;
    repeat (3) @(negedge clk);
    chk("R6 word held during read", db, old);
    rd_n = 1'b1; cs_n = 1'b1;
    repeat (5) @(negedge clk);
    model_write(3'd4, pat(4, 5));
    do_read(3'd4, 1'b0, "R6 result after release");
    do_read(3'd7, 1'b0, "R6 result queued");

    // R9: reset mid-run
    do_write(3'd1, pat(1, 3));
    do_read(3'd6, 1'b0, "R3 rotation before reset");
    do_reset();
    chk("R9 overflow cleared", {15'd0, ovf_flag}, 16'd0);
    do_read(3'd6, 1'b0, "R9 R3 rotation restarts at channel 0");
    do_read(3'd7, 1'b0, "R9 queue empty");
    do_read(3'd1, 1'b0, "R9 channel cleared");

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule